// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Controller

This block is the command-side logic of a serial flash slave. It watches a four-wire serial port (clock, active-low select, data in, data out) from the system clock domain. It recognises three commands: one that arms writing, one that erases a sector, and one that reads the status byte. A sector erase is honoured only when writing has been armed beforehand and no protection level is set. The select line must also return high exactly when the 32-bit frame is complete. Once an erase is accepted, the block sends a single-cycle request carrying the sector number to the memory array. It then holds a busy flag for a programmable number of system clock cycles.

Software observes progress by polling the status byte over the same serial port. While the busy flag is up, every command except the status read is dropped. The erase request is a plain one-cycle strobe, not a stream: the array must accept it in the cycle it appears, so there is no back-pressure on it. The protection level is a static configuration input, and its value is mirrored in the status byte.

Top module: `sflash_erase_ctrl`

## Requirements
- R1: After reset the status byte reads 00h (with protection level 0), and no erase request is issued.
- R2: A frame of exactly 8 bits carrying opcode 06h, closed by select rising, sets the write-arm flag (status bit 1).
- R3: After opcode 05h the status byte is driven on the data-out line, MSB first, one bit per falling serial clock edge. The byte repeats for as long as select stays low. Bit 0 is busy, bit 1 is write-arm, bits 4:2 are protection level bits 2:0, and bits 7:5 are 0.
- R4: A 32-bit frame is opcode D8h followed by a 24-bit address, MSB first. When it is closed by select rising after exactly 32 bits, with write-arm set and protection level 0, it produces one erase-request pulse of exactly one cycle. The pulse carries the sector number, which is address bits 19:16. Address bits 23:20 have no effect.
- R5: An erase frame received while write-arm is clear issues no request and leaves busy at 0.
- R6: An erase frame received while any protection level bit is 1 issues no request and leaves busy at 0.
- R7: A frame whose select rises after any bit count other than the one its opcode needs (8 for 06h, 32 for D8h) is discarded, and write-arm is left unchanged.
- R8: After an accepted erase the busy bit reads 1 for ERASE_CYCLES system clock cycles and then returns to 0. Write-arm is cleared in the same cycle that busy falls.
- R9: While busy is 1, erase and write-arm frames are ignored; status reads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial status data to the host |
| prot_lvl | input | 3 | Sector protection level; nonzero blocks erase |
| erase_valid | output | 1 | One-cycle erase request to the array |
| erase_sector | output | SECT_W | Sector number of the request |

## Verification
Each serial pin passes through SYNC_STAGES flops and one edge-detect flop. The erase request, the busy bit and each new data-out bit therefore change on the third rising system clock edge after the serial pin moves. The bench runs the serial clock at a half period of eight system cycles and samples data-out one system cycle before the next serial rising edge, well after that third edge. Erase requests are pushed into an expected-sector queue when a frame is sent, and a monitor compares them on the falling system clock edge. The busy window is checked by a status read issued shortly after acceptance (busy must still be 1) and another after ERASE_CYCLES have passed (busy and write-arm must be 0).

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_ERASE = 8'hD8;
  localparam int unsigned OPC_BITS = 8;

  typedef struct packed {
    logic [2:0] rsvd;
    logic [2:0] prot;
    logic       arm;
    logic       busy;
  } status_t;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= async_in;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
    end
  end

  assign level = pipe[STAGES-1];
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned SECT_W     = 4,
  parameter int unsigned SECT_LSB   = 16,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [7:0]        last_byte,
  output logic [7:0]        frame_op,
  output logic [SECT_W-1:0] frame_sect,
  output logic              byte_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(OPC_BITS - 1);

  logic [FRAME_BITS-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame    <= '0;
      bit_cnt  <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= sel && bit_stb && (bit_cnt == BYTE_END);
      if (!sel) begin
        bit_cnt <= '0;
      end else if (bit_stb) begin
        frame <= {frame[FRAME_BITS-2:0], bit_in};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign last_byte  = frame[7:0];
  assign frame_op   = frame[FRAME_BITS-1 -: 8];
  assign frame_sect = frame[SECT_LSB+SECT_W-1:SECT_LSB];

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt == '0));
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !bit_stb) |=> $stable(bit_cnt));
endmodule

// File: rtl/sfe_status_tx.sv
module sfe_status_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       shift_stb,
  input  logic [7:0] status_in,
  output logic       sdo
);
  logic [2:0] idx;
  logic [7:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      hold <= '0;
      sdo  <= 1'b0;
    end else if (!en) begin
      idx <= '0;
      sdo <= 1'b0;
    end else if (shift_stb) begin
      idx <= idx + 1'b1;
      if (idx == 3'd0) begin
        sdo  <= status_in[7];
        hold <= {status_in[6:0], 1'b0};
      end else begin
        sdo  <= hold[7];
        hold <= {hold[6:0], 1'b0};
      end
    end
  end

  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !shift_stb) |=> $stable(sdo));
endmodule

// File: rtl/sfe_erase_timer.sv
module sfe_erase_timer #(
  parameter int unsigned CYCLES = 100000,
  localparam int unsigned CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

  assign last = busy && (remain == '0);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sflash_erase_ctrl.sv
module sflash_erase_ctrl
  import sfe_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 100000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned ADDR_W       = 24,
  parameter int unsigned SECT_W       = 4,
  parameter int unsigned SECT_LSB     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  input  logic [2:0]        prot_lvl,
  output logic              erase_valid,
  output logic [SECT_W-1:0] erase_sector
);
  localparam int unsigned FRAME_BITS = OPC_BITS + ADDR_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(OPC_BITS);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);

  // synchronised pins: {csn, sck, sdi}
  logic [2:0] pins_lvl;
  sfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({spi_csn, spi_sck, spi_sdi}),
    .level(pins_lvl)
  );

  logic csn_lvl, sck_lvl, sdi_lvl, csn_q, sck_q;
  assign csn_lvl = pins_lvl[2];
  assign sck_lvl = pins_lvl[1];
  assign sdi_lvl = pins_lvl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_lvl;
      sck_q <= sck_lvl;
    end
  end

  logic sel, frame_end, sck_rise, sck_fall;
  assign sel       = ~csn_lvl;
  assign frame_end = csn_lvl & ~csn_q;
  assign sck_rise  = sck_lvl & ~sck_q;
  assign sck_fall  = ~sck_lvl & sck_q;

  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        last_byte, frame_op;
  logic [SECT_W-1:0] frame_sect;
  logic              byte_stb;

  sfe_shifter #(.FRAME_BITS(FRAME_BITS), .SECT_W(SECT_W), .SECT_LSB(SECT_LSB)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .bit_stb(sck_rise), .bit_in(sdi_lvl),
    .bit_cnt(bit_cnt), .last_byte(last_byte), .frame_op(frame_op),
    .frame_sect(frame_sect), .byte_stb(byte_stb)
  );

  logic busy, busy_last, arm, stat_on;
  logic arm_hit, erase_hit;

  assign arm_hit   = frame_end && !busy && (bit_cnt == CNT_OP) && (last_byte == OP_ARM);
  assign erase_hit = frame_end && !busy && arm && (prot_lvl == 3'b000)
                     && (bit_cnt == CNT_FRAME) && (frame_op == OP_ERASE);

  sfe_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(erase_hit), .busy(busy), .last(busy_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm          <= 1'b0;
      stat_on      <= 1'b0;
      erase_valid  <= 1'b0;
      erase_sector <= '0;
    end else begin
      if (busy_last)    arm <= 1'b0;
      else if (arm_hit) arm <= 1'b1;

      if (!sel)                                     stat_on <= 1'b0;
      else if (byte_stb && last_byte == OP_STAT)    stat_on <= 1'b1;

      erase_valid <= erase_hit;
      if (erase_hit) erase_sector <= frame_sect;
    end
  end

  status_t status;
  assign status = '{rsvd: 3'b000, prot: prot_lvl, arm: arm, busy: busy};

  sfe_status_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(stat_on), .shift_stb(sck_fall),
    .status_in(status), .sdo(spi_sdo)
  );

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |=> !erase_valid);
  assert_pulse_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |-> arm);
  assert_pulse_unprot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |-> ($past(prot_lvl) == 3'b000));
  assert_pulse_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |-> (busy && !$past(busy)));
  assert_arm_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !arm);
  assert_arm_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> !$rose(arm));
endmodule

// File: tb/sflash_erase_ctrl_bench.sv
module sflash_erase_ctrl_bench;
  localparam int ERASE = 2000;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [2:0] prot = 3'b000;
  logic sdo, erase_valid;
  logic [3:0] erase_sector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];
  logic exp_arm = 1'b0, exp_busy = 1'b0;

  always #10 clk = ~clk;

  sflash_erase_ctrl #(.ERASE_CYCLES(ERASE)) u_sflash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_sdi(sdi),
    .spi_sdo(sdo), .prot_lvl(prot), .erase_valid(erase_valid),
    .erase_sector(erase_sector)
  );

  // monitor: pops expected sectors as requests appear
  always @(negedge clk) begin
    if (rst_n && erase_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 R6 R7 R9: unexpected erase request sector %0d, expected none", erase_sector);
      end else begin
        int s;
        s = exp_q.pop_front();
        if (int'(erase_sector) != s) begin
          errors++;
          $display("FAIL R4: erase sector %0d, expected %0d", erase_sector, s);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    csn = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic cs_high();
    wait_cyc(HALF);
    csn = 1'b1;
    wait_cyc(4 * HALF);
  endtask

  task automatic send_bits(input logic [39:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_cyc(HALF);
      sck = 1'b1;
      wait_cyc(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic do_cmd(input logic [39:0] v, input int n);
    cs_low();
    send_bits(v, n);
    cs_high();
  endtask

  task automatic check_status(input int nbytes, input string tag);
    logic [7:0] exp;
    exp = {3'b000, prot, exp_arm, exp_busy};
    cs_low();
    send_bits(40'h05, 8);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] got;
      for (int k = 7; k >= 0; k--) begin
        wait_cyc(HALF - 1);
        got[k] = sdo;
        @(negedge clk);
        sck = 1'b1;
        wait_cyc(HALF);
        sck = 1'b0;
      end
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s: status byte %0d = %02h, expected %02h", tag, b, got, exp);
      end
    end
    cs_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1: reset state
    check_status(1, "R1");

    // R5: erase without arm
    do_cmd({8'hD8, 24'h030000}, 32);
    check_status(1, "R5");

    // R7: arm frame with 9 bits is discarded
    do_cmd({31'd0, 8'h06, 1'b0}, 9);
    check_status(1, "R7");

    // R2: arm; R3: repeated status bytes
    do_cmd(40'h06, 8);
    exp_arm = 1'b1;
    check_status(3, "R2 R3");

    // R6: protection blocks erase, R3 field position of protection bits
    prot = 3'b010;
    check_status(1, "R3");
    do_cmd({8'hD8, 24'h020000}, 32);
    check_status(1, "R6");
    prot = 3'b100;
    do_cmd({8'hD8, 24'h020000}, 32);
    check_status(1, "R6");
    prot = 3'b000;

    // R7: short and long erase frames discarded, arm kept
    do_cmd({8'hD8, 24'h040000} >> 1, 31);
    check_status(1, "R7");
    do_cmd({8'hD8, 24'h040000, 1'b1}, 33);
    check_status(1, "R7");

    // R4: accepted erase, upper address bits ignored -> sector 5
    exp_q.push_back(5);
    do_cmd({8'hD8, 24'hF5ABCD}, 32);
    exp_busy = 1'b1;
    check_status(1, "R8");

    // R9: commands during busy are ignored
    do_cmd({8'hD8, 24'h070000}, 32);
    do_cmd(40'h06, 8);
    check_status(2, "R9");

    // R8: busy ends, arm cleared
    wait_cyc(ERASE);
    exp_busy = 1'b0;
    exp_arm  = 1'b0;
    check_status(1, "R8");

    // R4: second erase, sector 10
    do_cmd(40'h06, 8);
    exp_q.push_back(10);
    do_cmd({8'hD8, 24'h0A1234}, 32);
    exp_arm = 1'b1;
    exp_busy = 1'b1;
    check_status(1, "R4");
    wait_cyc(ERASE);
    exp_busy = 1'b0;
    exp_arm  = 1'b0;
    check_status(1, "R8");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d erase requests missing, expected 0", exp_q.size());
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule